// File: doc/BRIEF.md
# Five-Valued Fault Propagation Evaluator

This block checks whether one stuck-at fault in a small gate network is both excited and carried to the network output. It models every net as a pair of values: the value in the fault-free circuit and the value in the faulty circuit. Each member of the pair is 0, 1 or unknown. The pair is reported as one of five symbols: 0, 1, X, D or D-bar. D means the fault-free value is 1 while the faulty value is 0. D-bar is the reverse. When either member is unknown, the pair reads as X.

Software first loads up to `MAX_GATES` gates through a write port. Each gate is an AND, OR, inverter or buffer, and each gate names its source nets. The network must be levelized: a gate reads only primary inputs or lower-numbered gates. A run starts with primary input values, a fault site and a stuck polarity. The block then evaluates one gate per clock in index order. It pulses `done` when the last gate is finished. It reports the five-valued value of the last gate and whether a discrepancy reached it.

Top module: `dalg_engine`

## Requirements
- R1: After reset, `done`, `busy` and `detected` are 0 and `out_val` reads the X code (2).
- R2: Net numbering and codes:
  - Nets 0 to NUM_IN-1 are the primary inputs. Gate g drives net NUM_IN+g.
  - Primary input i sits in `pi_vals[2i+1:2i]`, coded 00 for 0, 01 for 1, and 1x for X.
  - `out_val` is coded 0=0, 1=1, 2=X, 3=D, 4=D-bar.
  - `cfg_op` is coded 0=AND, 1=OR, 2=NOT, 3=BUF. NOT and BUF use source A only.
- R3: An inverter maps D to D-bar, D-bar to D, 0 to 1, 1 to 0, and X to X. A buffer passes its input unchanged.
- R4: AND produces these results:
  - D with 1 gives D.
  - D with 0 gives 0, so the fault effect is masked.
  - D with D-bar gives 0.
  - X with 1 gives X.
  - X with 0 gives 0.
- R5: OR produces these results:
  - D with 0 gives D.
  - D with 1 gives 1.
  - D with D-bar gives 1.
- R6: The fault is injected at its site, which may be a primary input or a gate output. The site's fault-free value is kept and its faulty value is forced to the stuck value. A stuck-at-0 site that is good 1 therefore becomes D. A stuck-at-1 site that is good 0 becomes D-bar.
- R7: A site whose fault-free value is X, or equals the stuck value, carries no discrepancy. The result then is not detected.
- R8: `detected` is 1 exactly when the reported `out_val` is D or D-bar.
- R9: Timing of a run:
  - The start is sampled at clock edge E0. Gates 0 to N-1 are evaluated at edges E1 to EN, where N is `num_gates` and 0 is treated as 1.
  - `done` is high for the single cycle after EN.
  - `out_val` and `detected` hold until the next run ends.
- R10: A `start` raised while `busy` is high is ignored. It causes neither a restart nor an extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one gate entry |
| cfg_gate | input | GATE_W (4) | Gate index being written |
| cfg_op | input | 2 | Gate operation code |
| cfg_src_a | input | NET_W (5) | First source net |
| cfg_src_b | input | NET_W (5) | Second source net |
| start | input | 1 | Begin a run (ignored while busy) |
| num_gates | input | CNT_W (5) | Number of gates to evaluate |
| pi_vals | input | 2*NUM_IN (8) | Ternary primary input values |
| fault_site | input | NET_W (5) | Net carrying the stuck-at fault |
| stuck_val | input | 1 | Stuck polarity (0 or 1) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| out_val | output | 3 | Five-valued value of the last gate |
| detected | output | 1 | Discrepancy reached the output |

## Verification
The hardest case to reach from the ports is a reconvergent path where D and D-bar meet at one gate. A single fault can only create both symbols through fanout. The stimulus feeds one faulted input both directly and through an inverter into the same AND or OR gate. A second hard case is a start request that arrives in the middle of a 16-gate chain. The bench issues a conflicting request mid-run and checks two things: the chain's odd-inverter result still arrives at the expected cycle, and no second completion follows.

// File: rtl/dalg_pkg.sv
package dalg_pkg;

    // Three-valued component of a good/faulty pair
    typedef enum logic [1:0] {T0 = 2'd0, T1 = 2'd1, TX = 2'd2} tern_t;

    // Five-valued reported symbol
    typedef enum logic [2:0] {
        FV0  = 3'd0,
        FV1  = 3'd1,
        FVX  = 3'd2,
        FVD  = 3'd3,
        FVDB = 3'd4
    } fv_t;

    typedef enum logic [1:0] {G_AND = 2'd0, G_OR = 2'd1, G_NOT = 2'd2, G_BUF = 2'd3} gop_t;

    typedef struct packed {
        tern_t good;
        tern_t bad;
    } pair_t;

    function automatic tern_t to_tern(input logic [1:0] v);
        return v[1] ? TX : (v[0] ? T1 : T0);
    endfunction

    function automatic tern_t t_and(input tern_t a, input tern_t b);
        if (a == T0 || b == T0) return T0;
        if (a == T1 && b == T1) return T1;
        return TX;
    endfunction

    function automatic tern_t t_or(input tern_t a, input tern_t b);
        if (a == T1 || b == T1) return T1;
        if (a == T0 && b == T0) return T0;
        return TX;
    endfunction

    function automatic tern_t t_not(input tern_t a);
        if (a == T0) return T1;
        if (a == T1) return T0;
        return TX;
    endfunction

    // Force the faulty component to the stuck polarity
    function automatic pair_t inject(input pair_t p, input logic pol);
        pair_t r;
        r.good = p.good;
        r.bad  = pol ? T1 : T0;
        return r;
    endfunction

    function automatic fv_t encode(input pair_t p);
        if (p.good == TX || p.bad == TX) return FVX;
        if (p.good == p.bad) return (p.good == T1) ? FV1 : FV0;
        return (p.good == T1) ? FVD : FVDB;
    endfunction

endpackage

// File: rtl/dalg_gate_table.sv
module dalg_gate_table
    import dalg_pkg::*;
#(
    parameter int MAX_GATES = 16,
    parameter int NET_W     = 5,
    localparam int GATE_W   = $clog2(MAX_GATES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [GATE_W-1:0] wr_idx,
    input  logic [1:0]        wr_op,
    input  logic [NET_W-1:0]  wr_a,
    input  logic [NET_W-1:0]  wr_b,
    input  logic [GATE_W-1:0] rd_idx,
    output gop_t              rd_op,
    output logic [NET_W-1:0]  rd_a,
    output logic [NET_W-1:0]  rd_b
);
    gop_t             op_q  [MAX_GATES];
    logic [NET_W-1:0] a_q   [MAX_GATES];
    logic [NET_W-1:0] b_q   [MAX_GATES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MAX_GATES; i++) begin
                op_q[i] <= G_BUF;
                a_q[i]  <= '0;
                b_q[i]  <= '0;
            end
        end else if (wr_en) begin
            op_q[wr_idx] <= gop_t'(wr_op);
            a_q[wr_idx]  <= wr_a;
            b_q[wr_idx]  <= wr_b;
        end
    end

    assign rd_op = op_q[rd_idx];
    assign rd_a  = a_q[rd_idx];
    assign rd_b  = b_q[rd_idx];
endmodule

// File: rtl/dalg_net_store.sv
module dalg_net_store
    import dalg_pkg::*;
#(
    parameter int NUM_IN    = 4,
    parameter int NUM_NETS  = 20,
    localparam int NET_W    = $clog2(NUM_NETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  pair_t            load_vals [NUM_IN],
    input  logic             wr_en,
    input  logic [NET_W-1:0] wr_addr,
    input  pair_t            wr_val,
    input  logic [NET_W-1:0] rd_a_addr,
    input  logic [NET_W-1:0] rd_b_addr,
    output pair_t            rd_a,
    output pair_t            rd_b
);
    localparam pair_t UNKNOWN = '{good: TX, bad: TX};

    pair_t nets [NUM_NETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_NETS; i++) nets[i] <= UNKNOWN;
        end else if (load) begin
            for (int i = 0; i < NUM_NETS; i++)
                nets[i] <= (i < NUM_IN) ? load_vals[i] : UNKNOWN;
        end else if (wr_en) begin
            nets[wr_addr] <= wr_val;
        end
    end

    assign rd_a = (int'(rd_a_addr) < NUM_NETS) ? nets[rd_a_addr] : UNKNOWN;
    assign rd_b = (int'(rd_b_addr) < NUM_NETS) ? nets[rd_b_addr] : UNKNOWN;
endmodule

// File: rtl/dalg_gate_eval.sv
module dalg_gate_eval
    import dalg_pkg::*;
(
    input  gop_t  op,
    input  pair_t a,
    input  pair_t b,
    output pair_t y
);
    always_comb begin
        unique case (op)
            G_AND: begin
                y.good = t_and(a.good, b.good);
                y.bad  = t_and(a.bad,  b.bad);
            end
            G_OR: begin
                y.good = t_or(a.good, b.good);
                y.bad  = t_or(a.bad,  b.bad);
            end
            G_NOT: begin
                y.good = t_not(a.good);
                y.bad  = t_not(a.bad);
            end
            default: y = a;
        endcase
    end

    // Five-valued rules checked at the symbol level
    always_comb begin
        if (op == G_NOT && encode(a) == FVD)
            assert_not_swaps_d_R3: assert (encode(y) == FVDB);
        if (op == G_AND && (encode(a) == FV0 || encode(b) == FV0))
            assert_and_controlled_R4: assert (encode(y) == FV0);
        if (op == G_OR && (encode(a) == FV1 || encode(b) == FV1))
            assert_or_controlled_R5: assert (encode(y) == FV1);
    end
endmodule

// File: rtl/dalg_seq.sv
module dalg_seq #(
    parameter int MAX_GATES = 16,
    localparam int GATE_W   = $clog2(MAX_GATES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [GATE_W-1:0] count_m1,
    output logic              accept,
    output logic              busy,
    output logic              last,
    output logic [GATE_W-1:0] ptr
);
    logic [GATE_W-1:0] cm_q;

    assign accept = start && !busy;
    assign last   = busy && (ptr == cm_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            ptr  <= '0;
            cm_q <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            ptr  <= '0;
            cm_q <= count_m1;
        end else if (busy) begin
            if (last) busy <= 1'b0;
            else      ptr  <= ptr + 1'b1;
        end
    end

    assert_run_advances_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> (busy && ptr == $past(ptr) + 1'b1));

    assert_run_ends_R9: assert property (@(posedge clk) disable iff (rst)
        last |=> !busy);
endmodule

// File: rtl/dalg_engine.sv
module dalg_engine
    import dalg_pkg::*;
#(
    parameter int NUM_IN    = 4,
    parameter int MAX_GATES = 16,
    localparam int NUM_NETS = NUM_IN + MAX_GATES,
    localparam int NET_W    = $clog2(NUM_NETS),
    localparam int GATE_W   = $clog2(MAX_GATES),
    localparam int CNT_W    = $clog2(MAX_GATES + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [GATE_W-1:0]   cfg_gate,
    input  logic [1:0]          cfg_op,
    input  logic [NET_W-1:0]    cfg_src_a,
    input  logic [NET_W-1:0]    cfg_src_b,
    input  logic                start,
    input  logic [CNT_W-1:0]    num_gates,
    input  logic [2*NUM_IN-1:0] pi_vals,
    input  logic [NET_W-1:0]    fault_site,
    input  logic                stuck_val,
    output logic                busy,
    output logic                done,
    output logic [2:0]          out_val,
    output logic                detected
);
    logic              accept, last;
    logic [GATE_W-1:0] ptr, count_m1;
    logic [NET_W-1:0]  site_q, gnet, src_a, src_b;
    logic              pol_q;
    gop_t              op;
    pair_t             in_pairs [NUM_IN];
    pair_t             va, vb, y, y_inj;
    fv_t               y_sym;

    assign count_m1 = (num_gates == '0) ? '0 : GATE_W'(num_gates - CNT_W'(1));

    // Primary input pairs with the fault applied at load time
    always_comb begin
        for (int i = 0; i < NUM_IN; i++) begin
            in_pairs[i].good = to_tern(pi_vals[2*i +: 2]);
            in_pairs[i].bad  = in_pairs[i].good;
            if (fault_site == NET_W'(i)) in_pairs[i] = inject(in_pairs[i], stuck_val);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            site_q <= '0;
            pol_q  <= 1'b0;
        end else if (accept) begin
            site_q <= fault_site;
            pol_q  <= stuck_val;
        end
    end

    dalg_seq #(.MAX_GATES(MAX_GATES)) u_seq (
        .clk(clk), .rst(rst), .start(start), .count_m1(count_m1),
        .accept(accept), .busy(busy), .last(last), .ptr(ptr)
    );

    dalg_gate_table #(.MAX_GATES(MAX_GATES), .NET_W(NET_W)) u_table (
        .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_idx(cfg_gate), .wr_op(cfg_op),
        .wr_a(cfg_src_a), .wr_b(cfg_src_b), .rd_idx(ptr),
        .rd_op(op), .rd_a(src_a), .rd_b(src_b)
    );

    assign gnet = NET_W'(NUM_IN + int'(ptr));

    dalg_net_store #(.NUM_IN(NUM_IN), .NUM_NETS(NUM_NETS)) u_nets (
        .clk(clk), .rst(rst), .load(accept), .load_vals(in_pairs),
        .wr_en(busy), .wr_addr(gnet), .wr_val(y_inj),
        .rd_a_addr(src_a), .rd_b_addr(src_b), .rd_a(va), .rd_b(vb)
    );

    dalg_gate_eval u_eval (.op(op), .a(va), .b(vb), .y(y));

    assign y_inj = (gnet == site_q) ? inject(y, pol_q) : y;
    assign y_sym = encode(y_inj);

    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            out_val  <= FVX;
            detected <= 1'b0;
        end else begin
            done <= last;
            if (last) begin
                out_val  <= y_sym;
                detected <= (y_sym == FVD) || (y_sym == FVDB);
            end
        end
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_detect_changes_at_done_R8: assert property (@(posedge clk) disable iff (rst)
        $changed(detected) |-> done);

    assert_start_busy_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (start && busy && !last) |=> busy);
endmodule

// File: tb/dalg_engine_bench.sv
module dalg_engine_bench;
    localparam int NUM_IN = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_gate = '0;
    logic [1:0] cfg_op = '0;
    logic [4:0] cfg_src_a = '0, cfg_src_b = '0;
    logic       start = 1'b0;
    logic [4:0] num_gates = 5'd1;
    logic [7:0] pi_vals = '0;
    logic [4:0] fault_site = '0;
    logic       stuck_val = 1'b0;
    logic       busy, done, detected;
    logic [2:0] out_val;

    dalg_engine u_dalg_engine (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_gate(cfg_gate), .cfg_op(cfg_op),
        .cfg_src_a(cfg_src_a), .cfg_src_b(cfg_src_b), .start(start),
        .num_gates(num_gates), .pi_vals(pi_vals), .fault_site(fault_site),
        .stuck_val(stuck_val), .busy(busy), .done(done), .out_val(out_val),
        .detected(detected)
    );

    always #5 clk = ~clk;

    // codes from R2
    localparam logic [1:0] P0 = 2'b00, P1 = 2'b01, PX = 2'b10;
    localparam logic [1:0] OP_AND = 2'd0, OP_OR = 2'd1, OP_NOT = 2'd2, OP_BUF = 2'd3;
    localparam logic [2:0] V0 = 3'd0, V1 = 3'd1, VX = 3'd2, VD = 3'd3, VDB = 3'd4;

    typedef struct {
        logic [2:0] val;
        logic       det;
        int         lat;
        int         t0;
        string      tag;
    } item_t;

    item_t exp_q[$];
    int checks = 0, fails = 0, cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Monitor: pops expected results as done pulses appear
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected done", 1, 0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check({it.tag, " out_val"}, int'(out_val), int'(it.val));
                check({"R8 ", it.tag, " detected"}, int'(detected), int'(it.det));
                check({"R9 ", it.tag, " latency"}, cyc - it.t0, it.lat);
            end
        end
    end

    task automatic cfg(input int g, input logic [1:0] op, input int a, input int b);
        @(negedge clk);
        cfg_we = 1'b1; cfg_gate = 4'(g); cfg_op = op;
        cfg_src_a = 5'(a); cfg_src_b = 5'(b);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Driver: pushes the expected item, then starts the run and waits for it
    task automatic run(input int n, input logic [7:0] pis, input int site, input logic pol,
                       input logic [2:0] ev, input logic ed, input string tag);
        item_t it;
        @(negedge clk);
        it.val = ev; it.det = ed; it.lat = n + 1; it.t0 = cyc; it.tag = tag;
        exp_q.push_back(it);
        num_gates = 5'(n); pi_vals = pis; fault_site = 5'(site); stuck_val = pol;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 100000 && !finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset done", int'(done), 0);
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset detected", int'(detected), 0);
        check("R1 reset out_val", int'(out_val), int'(VX));

        // R3 + R6: stuck-at-0 on PI 0, driven 1, through an inverter -> D-bar
        cfg(0, OP_NOT, 0, 0);
        run(1, {P0, P0, P0, P1}, 0, 1'b0, VDB, 1'b1, "R3 not of D");
        // R3: inverter of plain 0 gives 1, site unexcited
        run(1, {P0, P0, P0, P0}, 3, 1'b0, V1, 1'b0, "R3 not of 0");
        // R3: buffer passes D-bar from stuck-at-1 on PI 2 (R6)
        cfg(0, OP_BUF, 2, 0);
        run(1, {P0, P0, P0, P0}, 2, 1'b1, VDB, 1'b1, "R6 stuck1 buf");

        // R4: AND of nets 0 and 1
        cfg(0, OP_AND, 0, 1);
        run(1, {P0, P0, P1, P1}, 0, 1'b0, VD, 1'b1, "R4 D and 1");
        run(1, {P0, P0, P0, P1}, 0, 1'b0, V0, 1'b0, "R4 D and 0 masked");
        run(1, {P0, P0, P1, PX}, 3, 1'b0, VX, 1'b0, "R4 X and 1");
        run(1, {P0, P0, P0, PX}, 3, 1'b0, V0, 1'b0, "R4 X and 0");

        // R5: OR of nets 0 and 1
        cfg(0, OP_OR, 0, 1);
        run(1, {P0, P0, P0, P1}, 0, 1'b0, VD, 1'b1, "R5 D or 0");
        run(1, {P0, P0, P1, P1}, 0, 1'b0, V1, 1'b0, "R5 D or 1");

        // Reconvergence: gate0 = NOT(n0) -> D-bar, gate1 combines n0 (D) with net 4
        cfg(0, OP_NOT, 0, 0);
        cfg(1, OP_AND, 0, 4);
        run(2, {P0, P0, P0, P1}, 0, 1'b0, V0, 1'b0, "R4 D and Dbar");
        cfg(1, OP_OR, 0, 4);
        run(2, {P0, P0, P0, P1}, 0, 1'b0, V1, 1'b0, "R5 D or Dbar");

        // R6: fault on a gate output net (net 4 = AND of n0,n1), then inverted
        cfg(0, OP_AND, 0, 1);
        cfg(1, OP_NOT, 4, 0);
        run(2, {P0, P0, P1, P1}, 4, 1'b0, VDB, 1'b1, "R6 gate site");

        // R7: unexcited sites
        cfg(0, OP_BUF, 0, 0);
        run(1, {P0, P0, P0, PX}, 0, 1'b0, VX, 1'b0, "R7 site X");
        run(1, {P0, P0, P0, P0}, 0, 1'b0, V0, 1'b0, "R7 site equals stuck0");
        run(1, {P0, P0, P0, P1}, 0, 1'b1, V1, 1'b0, "R7 site equals stuck1");

        // R9: 16-gate chain, BUF then 15 inverters; odd count turns D into D-bar
        cfg(0, OP_BUF, 0, 0);
        for (int g = 1; g < 16; g++) cfg(g, OP_NOT, 3 + g, 0);
        run(16, {P0, P0, P0, P1}, 0, 1'b0, VDB, 1'b1, "R9 chain16");

        // R10: conflicting start mid-run is ignored
        begin
            item_t it;
            @(negedge clk);
            it.val = VDB; it.det = 1'b1; it.lat = 17; it.t0 = cyc; it.tag = "R10 busy start";
            exp_q.push_back(it);
            num_gates = 5'd16; pi_vals = {P0, P0, P0, P1}; fault_site = 5'd0; stuck_val = 1'b0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
            pi_vals = {P0, P0, P0, P0}; num_gates = 5'd2; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            while (exp_q.size() != 0) @(negedge clk);
            repeat (25) @(negedge clk);
            check("R10 busy after ignored start", int'(busy), 0);
            check("R9 out_val held", int'(out_val), int'(VDB));
            check("R9 detected held", int'(detected), 1);
            check("R9 done low after pulse", int'(done), 0);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule